// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block is the low-power controller of a small microcontroller core. When the core asks to halt, the block enters a sleep state and drops `core_ready`, which holds the core stalled. While asleep it watches four wake-up sources:

- an external reset request,
- falling edges on an 8-pin port, each pin gated by its own enable bit,
- a pending interrupt,
- a watchdog overflow pulse.

The first source to fire, chosen by a fixed priority, ends the sleep. The block then counts a start-up delay in system clocks. The length of that delay depends on the oscillator type and on which source woke the block. When the delay ends, the block raises `core_ready` and presents a one-cycle outcome code. The code tells the core what to do next: resume at the instruction after the halt, take the interrupt vector, perform a partial reset (program counter and stack pointer only), or perform a full reset.

The block also keeps two status flags, power-down and time-out, so software can tell why the core woke up. The outcome is a plain one-cycle pulse and has no back-pressure: the core must accept it in the cycle it appears, which a stalled-then-released core always can.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Out of reset, `core_ready` is 1 and `pdf`, `tof` and `outcome_valid` are 0. A `halt_req` while running makes `core_ready` 0 and `pdf` 1 from the next cycle on.
- R2: A falling edge on pin i wakes the block only when `port_wake_en[i]` is 1. Such a wake yields outcome 0 (resume), and it is detected two cycles later than a direct input because of the pin synchronizer. An edge on a disabled pin leaves the block asleep.
- R3: An interrupt wake yields outcome 1 (vector) when `irq_en` is 1 and `stack_full` is 0. Otherwise it yields outcome 0 (resume).
- R4: If `irq_pend` is already 1 when the halt is taken, that interrupt does not wake the block for the rest of that sleep.
- R5: A watchdog wake yields outcome 2 (partial reset). A `wdt_ovf` pulse sets `tof` on the next cycle.
- R6: An external-reset wake yields outcome 3 (full reset). Its delay is `POR_CYCLES + LONG_CYCLES`, regardless of oscillator type.
- R7: For port, interrupt and watchdog wakes, the delay is `SHORT_CYCLES` (2) when `osc_crystal` is 0 and `LONG_CYCLES` (128) when it is 1. `core_ready` stays 0 for exactly that many cycles after the cycle in which the wake is detected.
- R8: When wake sources arrive in the same cycle, they are ranked external reset, then watchdog, then interrupt, then port edge.
- R9: `outcome_valid` is 1 for exactly one cycle, the first cycle in which `core_ready` is 1 again, and `outcome` is valid in that cycle.
- R10: `clr_wdt` while running clears both `pdf` and `tof`. If `wdt_ovf` arrives in the same cycle, `tof` is set rather than cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| halt_req | input | 1 | Core requests sleep (one-cycle pulse) |
| clr_wdt | input | 1 | Clear-watchdog command from the core |
| osc_crystal | input | 1 | Static oscillator type: 1 = crystal, 0 = RC or internal |
| ext_rst | input | 1 | External reset request (synchronous pulse) |
| port_pins | input | 8 | Port pin levels (asynchronous) |
| port_wake_en | input | 8 | Per-pin wake-up enable mask |
| irq_pend | input | 1 | Interrupt request flag level |
| irq_en | input | 1 | Interrupt enable |
| stack_full | input | 1 | Core stack has no free level |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| core_ready | output | 1 | 1 when the core may run |
| outcome_valid | output | 1 | One-cycle strobe for `outcome` |
| outcome | output | 2 | 0 resume, 1 vector, 2 partial reset, 3 full reset |
| pdf | output | 1 | Power-down flag |
| tof | output | 1 | Time-out flag |

## Verification
The assertions take for granted the following about the inputs:

- `halt_req`, `ext_rst` and `wdt_ovf` are already synchronous to `clk`.
- `osc_crystal`, `irq_en` and `stack_full` do not change while a wake-up is being resolved.
- `halt_req` is only raised while `core_ready` is 1.

The stimulus keeps within these assumptions as follows. It changes inputs only at falling clock edges. It pulses `halt_req` only after the previous wake-up has completed. It holds the configuration and interrupt inputs fixed from the halt until the outcome strobe. The port pins are the only asynchronous inputs, and they reach the logic only through the synchronizer.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    OUT_RESUME   = 2'd0,
    OUT_VECTOR   = 2'd1,
    OUT_PART_RST = 2'd2,
    OUT_FULL_RST = 2'd3
  } slp_outcome_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAIT  = 2'd2
  } slp_state_e;

endpackage

// File: rtl/slp_port_edge.sv
module slp_port_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] wake_en,
  output logic         wake_req
);

  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] fell;

  // Two-flop synchronizer, then a one-sample history for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pins;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // The mask is applied per pin before the bits are reduced to one request.
  always_comb fell = prev_q & ~s2_q & wake_en;
  assign wake_req = |fell;

  p_mask_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (|wake_en));

endmodule

// File: rtl/slp_wake_arb.sv
module slp_wake_arb
  import slp_pkg::*;
#(
  parameter int CW           = 8,
  parameter int SHORT_CYCLES = 2,
  parameter int LONG_CYCLES  = 128,
  parameter int POR_CYCLES   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_ev,
  input  logic          wdt_ev,
  input  logic          irq_ev,
  input  logic          port_ev,
  input  logic          irq_en,
  input  logic          stack_full,
  input  logic          osc_crystal,
  output logic          any_wake,
  output slp_outcome_e  code,
  output logic [CW-1:0] delay
);

  localparam logic [CW-1:0] D_SHORT = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] D_LONG  = CW'(LONG_CYCLES);
  localparam logic [CW-1:0] D_EXT   = CW'(POR_CYCLES + LONG_CYCLES);

  logic [CW-1:0] osc_delay;

  assign any_wake  = ext_ev | wdt_ev | irq_ev | port_ev;
  assign osc_delay = osc_crystal ? D_LONG : D_SHORT;

  // Fixed priority: external reset, watchdog, interrupt, port edge.
  always_comb begin
    code  = OUT_RESUME;
    delay = osc_delay;
    if (ext_ev) begin
      code  = OUT_FULL_RST;
      delay = D_EXT;
    end else if (wdt_ev) begin
      code = OUT_PART_RST;
    end else if (irq_ev) begin
      code = (irq_en && !stack_full) ? OUT_VECTOR : OUT_RESUME;
    end
  end

  p_ext_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ev |-> (code == OUT_FULL_RST && delay == D_EXT));
  p_wdt_over_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ev && wdt_ev) |-> code == OUT_PART_RST);
  p_irq_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ev && !wdt_ev && irq_ev && irq_en && !stack_full) |-> code == OUT_VECTOR);

endmodule

// File: rtl/slp_delay_cnt.sv
module slp_delay_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  // Loaded with N-1 so that the wait state lasts exactly N cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expire) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slp_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter int SHORT_CYCLES = 2,
  parameter int LONG_CYCLES  = 128,
  parameter int POR_CYCLES   = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              clr_wdt,
  input  logic              osc_crystal,
  input  logic              ext_rst,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic              irq_pend,
  input  logic              irq_en,
  input  logic              stack_full,
  input  logic              wdt_ovf,
  output logic              core_ready,
  output logic              outcome_valid,
  output logic [1:0]        outcome,
  output logic              pdf,
  output logic              tof
);

  localparam int CW = $clog2(POR_CYCLES + LONG_CYCLES + 1);

  slp_state_e    state_q;
  slp_outcome_e  code, outc_q;
  logic          irq_block_q, valid_q, pdf_q, tof_q;
  logic          port_wake, irq_ev, any_wake, expire, load;
  logic [CW-1:0] delay;

  slp_port_edge #(.W(PORT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins(port_pins), .wake_en(port_wake_en),
    .wake_req(port_wake)
  );

  assign irq_ev = irq_pend & ~irq_block_q;

  slp_wake_arb #(
    .CW(CW), .SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES),
    .POR_CYCLES(POR_CYCLES)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .ext_ev(ext_rst), .wdt_ev(wdt_ovf),
    .irq_ev(irq_ev), .port_ev(port_wake), .irq_en(irq_en),
    .stack_full(stack_full), .osc_crystal(osc_crystal),
    .any_wake(any_wake), .code(code), .delay(delay)
  );

  assign load = (state_q == ST_SLEEP) && any_wake;

  slp_delay_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(delay), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      outc_q      <= OUT_RESUME;
      irq_block_q <= 1'b0;
      valid_q     <= 1'b0;
      pdf_q       <= 1'b0;
      tof_q       <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (wdt_ovf)      tof_q <= 1'b1;
      else if (clr_wdt) tof_q <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (halt_req) begin
            state_q     <= ST_SLEEP;
            pdf_q       <= 1'b1;
            irq_block_q <= irq_pend;
          end else if (clr_wdt) begin
            pdf_q <= 1'b0;
          end
        end
        ST_SLEEP: begin
          if (any_wake) begin
            state_q <= ST_WAIT;
            outc_q  <= code;
          end
        end
        ST_WAIT: begin
          if (expire) begin
            state_q <= ST_RUN;
            valid_q <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign core_ready    = (state_q == ST_RUN);
  assign outcome_valid = valid_q;
  assign outcome       = outc_q;
  assign pdf           = pdf_q;
  assign tof           = tof_q;

  p_halt_sleeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && core_ready) |=> (!core_ready && pdf));
  p_blocked_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && irq_block_q && !ext_rst && !wdt_ovf && !port_wake)
      |=> state_q == ST_SLEEP);
  p_tof_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> tof);
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !expire) |=> !core_ready);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outcome_valid |=> !outcome_valid);
  p_valid_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outcome_valid |-> core_ready);

endmodule

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;

  localparam int POR = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 0, clr_wdt = 0, osc_crystal = 0, ext_rst = 0;
  logic [7:0] port_pins = 8'hFF, port_wake_en = 8'h01;
  logic       irq_pend = 0, irq_en = 0, stack_full = 0, wdt_ovf = 0;
  logic       core_ready, outcome_valid, pdf, tof;
  logic [1:0] outcome;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.POR_CYCLES(POR)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clr_wdt(clr_wdt),
    .osc_crystal(osc_crystal), .ext_rst(ext_rst), .port_pins(port_pins),
    .port_wake_en(port_wake_en), .irq_pend(irq_pend), .irq_en(irq_en),
    .stack_full(stack_full), .wdt_ovf(wdt_ovf), .core_ready(core_ready),
    .outcome_valid(outcome_valid), .outcome(outcome), .pdf(pdf), .tof(tof)
  );

  typedef struct packed {
    logic        port;
    logic        irq;
    logic        wdt;
    logic        ext;
    logic        osc;
    logic        ien;
    logic        sfull;
    logic [1:0]  code;
    logic [15:0] wait_n;
  } vec_t;

  // Expected wait = delay + 1 negedge, plus 2 for the port synchronizer.
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'd5},    // R2 R7 port, RC
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,16'd131},  // R2 R7 port, crystal
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,16'd3},    // R3 vector
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,16'd3},    // R3 stack full
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,16'd129},  // R3 disabled, crystal
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd2,16'd3},    // R5 wdt RC
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd2,16'd129},  // R5 wdt crystal
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,16'd169},  // R6 ext RC
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'd3,16'd169},  // R8 all four
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'd2,16'd3},    // R8 wdt over irq
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'd1,16'd129}   // R8 irq over port
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_halt();
    @(negedge clk) halt_req = 1'b1;
    @(negedge clk) halt_req = 1'b0;
    chk(!core_ready, "R1 ready low", int'(core_ready), 0);
    chk(pdf, "R1 pdf set", int'(pdf), 1);
  endtask

  // Waits for ready and checks wait length, outcome code and strobe width.
  task automatic await_wake(input int exp_wait, input int exp_code, input string req);
    int n = 0;
    while (!core_ready && n < 400) begin
      @(negedge clk);
      n++;
      ext_rst = 1'b0;
      wdt_ovf = 1'b0;
    end
    chk(n == exp_wait, {req, " R7 delay"}, n, exp_wait);
    chk(outcome_valid && outcome == 2'(exp_code), {req, " R9 outcome"},
        int'(outcome), exp_code);
    @(negedge clk);
    chk(!outcome_valid, "R9 single strobe", int'(outcome_valid), 0);
  endtask

  task automatic clear_flags();
    @(negedge clk) clr_wdt = 1'b1;
    @(negedge clk) clr_wdt = 1'b0;
    chk(!pdf && !tof, "R10 flags cleared", int'({pdf, tof}), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(core_ready && !pdf && !tof && !outcome_valid, "R1 reset state",
        int'({core_ready, pdf, tof, outcome_valid}), 8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      osc_crystal  = VECS[i].osc;
      irq_en       = VECS[i].ien;
      stack_full   = VECS[i].sfull;
      port_wake_en = 8'h01;
      do_halt();
      repeat (2) @(negedge clk);
      if (VECS[i].port) port_pins = 8'hFE;
      irq_pend = VECS[i].irq;
      wdt_ovf  = VECS[i].wdt;
      ext_rst  = VECS[i].ext;
      await_wake(int'(VECS[i].wait_n), int'(VECS[i].code), "vec");
      chk(tof == VECS[i].wdt, "R5 tof", int'(tof), int'(VECS[i].wdt));
      port_pins = 8'hFF;
      irq_pend  = 1'b0;
      repeat (3) @(negedge clk);
      clear_flags();
    end

    // R2: disabled pin edge is ignored, enabled pin edge wakes.
    osc_crystal = 1'b0;
    port_wake_en = 8'h01;
    do_halt();
    port_pins = 8'hF7;
    repeat (10) @(negedge clk);
    chk(!core_ready, "R2 masked pin ignored", int'(core_ready), 0);
    port_pins = 8'hF6;
    await_wake(5, 0, "R2");
    port_pins = 8'hFF;
    repeat (3) @(negedge clk);
    clear_flags();

    // R4: interrupt pending at halt does not wake.
    irq_en = 1'b1;
    irq_pend = 1'b1;
    do_halt();
    repeat (10) @(negedge clk);
    chk(!core_ready, "R4 pending irq no wake", int'(core_ready), 0);
    wdt_ovf = 1'b1;
    await_wake(3, 2, "R4");
    irq_pend = 1'b0;
    clear_flags();

    // R10: overflow wins over clear in the same cycle.
    @(negedge clk) begin clr_wdt = 1'b1; wdt_ovf = 1'b1; end
    @(negedge clk) begin clr_wdt = 1'b0; wdt_ovf = 1'b0; end
    chk(tof, "R10 ovf beats clear", int'(tof), 1);
    chk(core_ready, "R5 ovf while running keeps ready", int'(core_ready), 1);
    clear_flags();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule